// File: doc/BRIEF.md
# Software Watchdog Timer with Selectable Timeout Action

This block guards a system against software that has stopped making progress. Once software enables it, a free-running counter climbs every clock cycle. If software restarts it in time, nothing happens. Software restarts it by writing a two-byte unlock pair to the service register. If the count reaches the selected period first, the block raises one of two outputs. The first is a one-cycle system reset request. The second is a level-7 interrupt request, which stays high until software acknowledges it.

Configuration goes through a small register write port. The control register holds the enable bit, the action select bit and the period code. It accepts only the first write after reset, so runaway code cannot turn the watchdog off or stretch its period. The period code chooses one of eight timeouts. They run from 2^9 to 2^23 clock cycles in steps of a factor of four. After every timeout the count starts again from zero.

Top module: `soft_watchdog`

## Requirements
- R1: While reset is held, and right after it is released, `rst_req` and `irq7_req` are low and the counter is stopped.
- R2: A write to address 0 sets the control fields: bit 0 is enable, bit 1 is the action (0 = reset, 1 = interrupt), and bits 4:2 are the period code. Only the first such write after reset takes effect. Every later write to address 0 is ignored.
- R3: While enable is 0, neither `rst_req` nor `irq7_req` is ever raised.
- R4: Period code k gives a timeout of P = 2^(9+2k) cycles. The timeout output changes P clock edges after the edge that wrote the enable, or after the edge of the last restart.
- R5: When the action is reset, a timeout raises `rst_req` for exactly one cycle.
- R6: When the action is interrupt, a timeout sets `irq7_req`. It stays high until a write to address 2 with bit 0 = 1, and it is low from the edge of that write onward.
- R7: Two writes to address 1, first 0x55 and then 0xAA, with no other address-1 write between them, restart the count from zero at the edge of the 0xAA write.
- R8: Any other sequence of address-1 writes leaves the count running. Examples are 0xAA alone, or 0x55 followed by a different value and then 0xAA.
- R9: After a timeout the count restarts from zero, so the next timeout follows P cycles later. If `irq7_req` is still high at that point, it simply stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 service, 2 acknowledge |
| wr_data | input | 8 | Write data |
| rst_req | output | 1 | One-cycle reset request on timeout |
| irq7_req | output | 1 | Level-7 interrupt request, held until acknowledged |

## Verification
Each timeout output is due exactly P edges after the edge of the enabling write or of the most recent valid restart. Acknowledge and lock effects are due on the write edge itself. The driver records the edge number of every write it issues. It pushes an expected event, tagged with its kind, into a queue for edge plus P. The monitor samples on falling edges and pops one entry for each reset pulse cycle and each rising edge of the interrupt. It then compares the kind and the edge number, so a pulse that arrives early, arrives late, or lasts two cycles shows up as a mismatch or as an unexpected event. Phases in which nothing may fire are checked by counting the events seen and expecting zero.

// File: rtl/swd_pkg.sv
package swd_pkg;

  // Register addresses on the write port.
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_SVC  = 2'd1;
  localparam logic [1:0] ADDR_ACK  = 2'd2;

  // Service unlock pair.
  localparam logic [7:0] SVC_FIRST  = 8'h55;
  localparam logic [7:0] SVC_SECOND = 8'hAA;

  typedef enum logic {ACT_RESET = 1'b0, ACT_IRQ = 1'b1} swd_action_e;

  // log2 of the timeout length for a period code.
  function automatic int unsigned swd_period_log2(input int unsigned code,
                                                  input int unsigned base_log2,
                                                  input int unsigned step_log2);
    return base_log2 + step_log2 * code;
  endfunction

  // Last count value before a timeout: 2^log2 - 1.
  function automatic logic [31:0] swd_terminal(input int unsigned log2v);
    logic [32:0] one_shift;
    one_shift = 33'd1 << log2v;
    return 32'(one_shift - 33'd1);
  endfunction

endpackage

// File: rtl/swd_regs.sv
module swd_regs
  import swd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ctrl_en,
  output swd_action_e       ctrl_act,
  output logic [PSEL_W-1:0] ctrl_per,
  output logic              kick,
  output logic              ack_wr
);

  logic locked;
  logic armed;
  logic ctrl_wr;
  logic svc_wr;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign svc_wr  = wr_en && (wr_addr == ADDR_SVC);
  assign ack_wr  = wr_en && (wr_addr == ADDR_ACK) && wr_data[0];
  assign kick    = svc_wr && armed && (wr_data[7:0] == SVC_SECOND);

  // Write-once control fields.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      ctrl_en  <= 1'b0;
      ctrl_act <= ACT_RESET;
      ctrl_per <= '0;
    end else if (ctrl_wr && !locked) begin
      locked   <= 1'b1;
      ctrl_en  <= wr_data[0];
      ctrl_act <= swd_action_e'(wr_data[1]);
      ctrl_per <= wr_data[2 +: PSEL_W];
    end
  end

  // Unlock-pair tracker: any service write other than the first byte disarms.
  always_ff @(posedge clk) begin
    if (!rst_n)      armed <= 1'b0;
    else if (svc_wr) armed <= (wr_data[7:0] == SVC_FIRST);
  end

  p_lock_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(ctrl_en) && $stable(ctrl_act) && $stable(ctrl_per)));

  p_kick_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && wr_data[7:0] != SVC_FIRST) |=> !kick);

endmodule

// File: rtl/swd_counter.sv
module swd_counter
  import swd_pkg::*;
#(
  parameter int PSEL_W    = 3,
  parameter int BASE_LOG2 = 9,
  parameter int STEP_LOG2 = 2,
  parameter int CNT_W     = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [PSEL_W-1:0] per_code,
  input  logic              kick,
  output logic              expire
);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] terminal;

  assign terminal = CNT_W'(swd_terminal(swd_period_log2(int'(per_code),
                                                        BASE_LOG2, STEP_LOG2)));
  assign expire   = enable && !kick && (count == terminal);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) count <= '0;
    else if (kick || expire) count <= '0;
    else count <= count + 1'b1;
  end

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= terminal);

  p_kick_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && kick) |=> (count == '0));

  p_wrap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count == '0));

endmodule

// File: rtl/swd_action.sv
module swd_action
  import swd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        expire,
  input  swd_action_e act,
  input  logic        ack_wr,
  output logic        rst_req,
  output logic        irq_req
);

  logic fire_rst;
  logic fire_irq;

  assign fire_rst = expire && (act == ACT_RESET);
  assign fire_irq = expire && (act == ACT_IRQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      irq_req <= 1'b0;
    end else begin
      rst_req <= fire_rst;
      if (fire_irq)    irq_req <= 1'b1;
      else if (ack_wr) irq_req <= 1'b0;
    end
  end

  p_rst_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !ack_wr) |=> irq_req);

  p_irq_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !fire_irq) |=> !irq_req);

endmodule

// File: rtl/soft_watchdog.sv
module soft_watchdog
  import swd_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PSEL_W    = 3,
  parameter int BASE_LOG2 = 9,
  parameter int STEP_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rst_req,
  output logic              irq7_req
);

  localparam int NUM_PER = 1 << PSEL_W;
  localparam int CNT_W   = BASE_LOG2 + STEP_LOG2 * (NUM_PER - 1);

  logic              ctrl_en;
  swd_action_e       ctrl_act;
  logic [PSEL_W-1:0] ctrl_per;
  logic              kick;
  logic              ack_wr;
  logic              expire;

  swd_regs #(.DATA_W(DATA_W), .PSEL_W(PSEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_en(ctrl_en), .ctrl_act(ctrl_act),
    .ctrl_per(ctrl_per), .kick(kick), .ack_wr(ack_wr)
  );

  swd_counter #(.PSEL_W(PSEL_W), .BASE_LOG2(BASE_LOG2),
                .STEP_LOG2(STEP_LOG2), .CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .enable(ctrl_en), .per_code(ctrl_per),
    .kick(kick), .expire(expire)
  );

  swd_action u_action (
    .clk(clk), .rst_n(rst_n), .expire(expire), .act(ctrl_act),
    .ack_wr(ack_wr), .rst_req(rst_req), .irq_req(irq7_req)
  );

  p_quiet_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> (!rst_req && !$rose(irq7_req)));

  p_one_action_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_act == ACT_IRQ) |=> !rst_req);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!rst_req && !irq7_req));

endmodule

// File: tb/test_soft_watchdog.sv
module test_soft_watchdog;

  typedef struct {
    int cyc;
    bit is_irq;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rst_req;
  logic       irq7_req;

  int   cyc = 0;
  int   n_tests = 0;
  int   n_fail = 0;
  int   n_events = 0;
  bit   prev_irq = 1'b0;
  exp_t sb[$];

  soft_watchdog i_soft_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rst_req(rst_req), .irq7_req(irq7_req)
  );

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int period_of(input int code);
    return 1 << (9 + 2 * code);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Driver: one register write, returns the edge number that captured it.
  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int edge_no);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    edge_no = cyc;
    wr_en = 1'b0;
  endtask

  task automatic push(input int c, input bit irq, input string req);
    exp_t e;
    e.cyc = c; e.is_irq = irq; e.req = req;
    sb.push_back(e);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(rst_req == 1'b0 && irq7_req == 1'b0, "R1", "outputs low in reset",
          int'(rst_req) + int'(irq7_req), 0);
    sb.delete();
    rst_n = 1'b1;
  endtask

  task automatic drain_check();
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(1'b0, e.req, "expected event never seen at cycle", -1, e.cyc);
    end
  endtask

  // Monitor: pop and compare on every reset pulse cycle and interrupt rise.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_req) handle_event(1'b0);
      if (irq7_req && !prev_irq) handle_event(1'b1);
    end
    prev_irq = irq7_req;
  end

  task automatic handle_event(input bit irq);
    exp_t e;
    n_events++;
    if (sb.size() == 0) begin
      check(1'b0, "R3", irq ? "unexpected irq rise" : "unexpected rst pulse",
            cyc, -1);
    end else begin
      e = sb.pop_front();
      check(e.is_irq == irq && e.cyc == cyc, e.req,
            irq ? "irq rise cycle" : "rst pulse cycle", cyc, e.cyc);
    end
  endtask

  initial begin
    #1600000;
    check(1'b0, "WDOG", "bench watchdog expired", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int e0, e1, s;
    do_reset();
    @(negedge clk);
    check(rst_req == 1'b0 && irq7_req == 1'b0, "R1", "outputs low after release",
          int'(rst_req) + int'(irq7_req), 0);

    // Phase A: disabled, and a later enable write is ignored (R3, R2).
    n_events = 0;
    wr(2'd0, 8'h00, e0);
    wait_until(e0 + 1200);
    check(n_events == 0, "R3", "events while disabled", n_events, 0);
    wr(2'd0, 8'h01, e1);
    wait_until(e1 + 1200);
    check(n_events == 0, "R2", "events after ignored second ctrl write",
          n_events, 0);

    // Phase B: reset action, period code 0, service sequences.
    do_reset();
    wr(2'd0, 8'h01, e0);
    wr(2'd0, 8'h05, e1);              // R2: ignored, period stays 512
    wait_until(e0 + 100);
    wr(2'd1, 8'h55, e1);
    wr(2'd1, 8'hAA, s);               // R7: valid restart
    push(s + period_of(0), 1'b0, "R7");
    wait_until(s + 200);
    wr(2'd1, 8'h55, e1);
    wr(2'd1, 8'h12, e1);
    wr(2'd1, 8'hAA, e1);              // R8: broken pair
    wr(2'd1, 8'hAA, e1);              // R8: second byte alone
    wr(2'd3, 8'hAA, e1);              // other address
    wait_until(s + period_of(0) + 5);
    check(sb.size() == 0, "R5", "rst pulse at first timeout consumed",
          sb.size(), 0);
    push(s + 2 * period_of(0), 1'b0, "R9");
    wait_until(s + 2 * period_of(0) + 5);
    check(sb.size() == 0, "R9", "rst pulse after wrap consumed", sb.size(), 0);
    check(rst_req == 1'b0, "R5", "rst_req back low", int'(rst_req), 0);

    // Phase C: interrupt action, period code 1.
    do_reset();
    wr(2'd0, 8'h07, e0);
    push(e0 + period_of(1), 1'b1, "R4");
    wait_until(e0 + period_of(1) + 50);
    @(negedge clk);
    check(irq7_req == 1'b1, "R6", "irq held before ack", int'(irq7_req), 1);
    wr(2'd2, 8'h00, e1);              // bit 0 clear: no acknowledge
    @(negedge clk);
    check(irq7_req == 1'b1, "R6", "irq held after ack with bit0=0",
          int'(irq7_req), 1);
    wr(2'd2, 8'h01, e1);
    @(negedge clk);
    check(irq7_req == 1'b0, "R6", "irq cleared by ack", int'(irq7_req), 0);
    push(e0 + 2 * period_of(1), 1'b1, "R9");
    wait_until(e0 + 3 * period_of(1) + 20);   // third expiry while irq high
    @(negedge clk);
    check(irq7_req == 1'b1, "R9", "irq stays high across expiry",
          int'(irq7_req), 1);
    wr(2'd2, 8'h01, e1);
    push(e0 + 4 * period_of(1), 1'b1, "R9");
    wait_until(e0 + 4 * period_of(1) + 5);
    check(rst_req == 1'b0, "R5", "no rst pulse in irq mode", int'(rst_req), 0);

    drain_check();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule